// File: doc/BRIEF.md
# Receive Mailbox Allocator with Overwrite Protection

This block sits behind a CAN-style frame receiver. The receiver hands it frames that are already checked. It chooses which of a bank of message mailboxes receives each frame. Each mailbox holds the following state:

- an identifier word with control bits and an acceptance mask;
- enable, receive-direction and overwrite-protect bits;
- the stored length code, remote flag and eight data bytes.

When a frame strobe arrives, every mailbox compares the frame identifier against its own filter in parallel. The frame goes to the highest-numbered eligible mailbox. A pending bit marks a mailbox that holds an unread frame. Overwrite protection and the per-mailbox lost bits decide what happens when that mailbox is already full.

Software reaches the block through three paths:

- a single-cycle configuration write port, which loads one mailbox's enable, direction, protection, identifier word and mask;
- write-one-to-clear vectors for the pending bits, the lost bits and the global lost flag;
- a combinational read port, which returns the stored contents of one mailbox.

Top module: `rxmb_allocator`

## Requirements
- R1: After reset all pending bits, all lost bits and the global lost flag read 0, and every mailbox is disabled, so no frame is stored.
- R2: A mailbox can take a frame only when its enable bit is 1 and its direction bit is 1 (1 = receive). A disabled mailbox or a transmit-direction mailbox never becomes pending.
- R3: Acceptance filtering works on the identifier word. Bit 31 is the extended flag, bit 30 is the mask enable and bit 29 is the auto-answer bit.
  - A frame identifier is aligned to bits [28:0] when extended. A standard 11-bit identifier goes to bits [28:18], and for a standard frame only bits [28:18] are compared.
  - When bit 30 is 1, each mask bit [28:0] set to 1 makes that identifier bit don't-care. Mask bit 29 set to 1 makes the extended flag don't-care. When bit 30 is 0, every compared bit and the extended flag must match exactly.
- R4: When the highest-numbered matching mailbox is not pending, the frame is stored there and only that pending bit rises, one clock after the strobe.
- R5: A stored frame reads back as follows:
  - the identifier word holds the frame's extended flag at bit 31 and the aligned identifier at [28:0], with bits 30 and 29 kept from the configuration;
  - the control field holds the remote flag at bit 4 and the length code at [3:0];
  - the low data word is frame data bits [31:0] and the high word is bits [63:32].
- R6: A pending bit is cleared by writing 1 to its clear input. If a frame is stored into the same mailbox in the same cycle, the bit stays set. The placement decision always uses the pending values from before that cycle's clear.
- R7: When the highest matching mailbox is pending and not protected, the new frame overwrites it, and that mailbox's lost bit and the global lost flag are set.
- R8: When the highest matching mailbox is pending and protected, the frame goes to the highest-numbered matching mailbox that is not pending, and no lost bit changes.
- R9: When the highest matching mailbox is pending and protected and no matching mailbox is free, the frame is dropped. The first-choice mailbox's lost bit and the global lost flag are set, and no stored contents change.
- R10: The global lost flag is sticky until its clear input is pulsed, and lost bits clear by writing 1. A lost event in the same cycle as a clear leaves the bit set.
- R11: A frame that matches no mailbox changes no pending bit, lost bit, flag or stored contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W | Mailbox written by the configuration port |
| cfg_en | input | 1 | Mailbox enable value |
| cfg_rx | input | 1 | Direction value, 1 = receive |
| cfg_prot | input | 1 | Overwrite-protect value |
| cfg_id_word | input | 32 | Identifier word with control bits 31..29 |
| cfg_mask | input | 30 | Acceptance mask, bit 29 masks the extended flag |
| frm_valid | input | 1 | Received-frame strobe |
| frm_ide | input | 1 | Frame uses an extended identifier |
| frm_rtr | input | 1 | Remote frame flag |
| frm_id | input | 29 | Frame identifier, standard in [10:0] |
| frm_dlc | input | 4 | Length code |
| frm_data | input | 64 | Data bytes, byte 0 in [7:0] |
| pend_clr | input | NUM_MB | Write-one-to-clear for pending bits |
| lost_clr | input | NUM_MB | Write-one-to-clear for lost bits |
| lost_flag_clr | input | 1 | Clear for the global lost flag |
| rd_idx | input | IDX_W | Mailbox selected for read-back |
| rd_id_word | output | 32 | Selected identifier word |
| rd_ctrl | output | 5 | Selected remote flag and length code |
| rd_data_lo | output | 32 | Selected low data word |
| rd_data_hi | output | 32 | Selected high data word |
| pending | output | NUM_MB | Receive-pending bits |
| lost | output | NUM_MB | Message-lost bits |
| lost_flag | output | 1 | Global receive-lost flag |

## Verification
Software's write-one-to-clear of a pending bit can fall in the same cycle as the storage of a new frame, and the two pull that bit in opposite directions. The bench provokes this in two ways: with a directed case where the cleared mailbox is also the chosen target, and with a pseudo-random sweep that pairs clear vectors with frame strobes. The pending vector read one cycle later must show the stored bit set. The placement must match a model that decides on the pending values from before the clear. Lost events meeting a lost-bit or flag clear are judged the same way.

// File: rtl/rxmb_pkg.sv
package rxmb_pkg;
    localparam int ID_W    = 29;
    localparam int STD_W   = 11;
    localparam int STD_LSB = ID_W - STD_W;
    localparam int MASK_W  = ID_W + 1;
    localparam int DLC_W   = 4;
    localparam int DATA_W  = 64;
    localparam int WORD_W  = 32;

    typedef struct packed {
        logic            ide;
        logic            ame;
        logic            aam;
        logic [ID_W-1:0] id;
    } id_word_t;

    typedef struct packed {
        logic              en;
        logic              rx;
        logic              prot;
        logic [MASK_W-1:0] mask;
        id_word_t          idw;
        logic              rtr;
        logic [DLC_W-1:0]  dlc;
        logic [DATA_W-1:0] data;
    } mbox_t;

    function automatic logic [ID_W-1:0] align_id(input logic ide, input logic [ID_W-1:0] id);
        return ide ? id : {id[STD_W-1:0], {STD_LSB{1'b0}}};
    endfunction
endpackage

// File: rtl/rxmb_accept.sv
module rxmb_accept
    import rxmb_pkg::*;
#(
    parameter int NUM_MB = 8
) (
    input  mbox_t [NUM_MB-1:0] mb_i,
    input  logic               ide_i,
    input  logic [ID_W-1:0]    fid_i,
    output logic [NUM_MB-1:0]  hit_o
);
    localparam logic [ID_W-1:0] STD_CARE = {{STD_W{1'b1}}, {STD_LSB{1'b0}}};

    for (genvar i = 0; i < NUM_MB; i++) begin : g_mb
        logic [ID_W-1:0] dont_care;
        logic [ID_W-1:0] care;
        logic            ide_ok;
        assign dont_care = mb_i[i].idw.ame ? mb_i[i].mask[ID_W-1:0] : '0;
        assign care      = ~dont_care & (ide_i ? {ID_W{1'b1}} : STD_CARE);
        assign ide_ok    = (mb_i[i].idw.ide == ide_i) ||
                           (mb_i[i].idw.ame && mb_i[i].mask[MASK_W-1]);
        assign hit_o[i]  = mb_i[i].en && mb_i[i].rx && ide_ok &&
                           (((fid_i ^ mb_i[i].idw.id) & care) == '0);
    end
endmodule

// File: rtl/rxmb_pick.sv
module rxmb_pick #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  req_i,
    output logic          found_o,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = 0; i < N; i++) begin
            if (req_i[i]) begin
                found_o = 1'b1;
                idx_o   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/rxmb_allocator.sv
module rxmb_allocator
    import rxmb_pkg::*;
#(
    parameter  int NUM_MB = 8,
    localparam int IDX_W  = (NUM_MB > 1) ? $clog2(NUM_MB) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [IDX_W-1:0]    cfg_idx,
    input  logic                cfg_en,
    input  logic                cfg_rx,
    input  logic                cfg_prot,
    input  logic [WORD_W-1:0]   cfg_id_word,
    input  logic [MASK_W-1:0]   cfg_mask,
    input  logic                frm_valid,
    input  logic                frm_ide,
    input  logic                frm_rtr,
    input  logic [ID_W-1:0]     frm_id,
    input  logic [DLC_W-1:0]    frm_dlc,
    input  logic [DATA_W-1:0]   frm_data,
    input  logic [NUM_MB-1:0]   pend_clr,
    input  logic [NUM_MB-1:0]   lost_clr,
    input  logic                lost_flag_clr,
    input  logic [IDX_W-1:0]    rd_idx,
    output logic [WORD_W-1:0]   rd_id_word,
    output logic [DLC_W:0]      rd_ctrl,
    output logic [WORD_W-1:0]   rd_data_lo,
    output logic [WORD_W-1:0]   rd_data_hi,
    output logic [NUM_MB-1:0]   pending,
    output logic [NUM_MB-1:0]   lost,
    output logic                lost_flag
);
    typedef struct packed {
        mbox_t [NUM_MB-1:0] mb;
        logic  [NUM_MB-1:0] pend;
        logic  [NUM_MB-1:0] lost;
        logic               flag;
    } state_t;

    state_t             st_q, st_d;
    logic [ID_W-1:0]    fid;
    logic [NUM_MB-1:0]  hit;
    logic [NUM_MB-1:0]  free_hit;
    logic               best_found, free_found;
    logic [IDX_W-1:0]   best_idx, free_idx;

    assign fid = align_id(frm_ide, frm_id);

    rxmb_accept #(.NUM_MB(NUM_MB)) u_accept (
        .mb_i  (st_q.mb),
        .ide_i (frm_ide),
        .fid_i (fid),
        .hit_o (hit)
    );

    assign free_hit = hit & ~st_q.pend;

    rxmb_pick #(.N(NUM_MB), .IW(IDX_W)) u_pick_best (
        .req_i   (hit),
        .found_o (best_found),
        .idx_o   (best_idx)
    );

    rxmb_pick #(.N(NUM_MB), .IW(IDX_W)) u_pick_free (
        .req_i   (free_hit),
        .found_o (free_found),
        .idx_o   (free_idx)
    );

    always_comb begin
        logic             store;
        logic             mark_lost;
        logic [IDX_W-1:0] tgt;
        st_d      = st_q;
        store     = 1'b0;
        mark_lost = 1'b0;
        tgt       = best_idx;
        st_d.pend = st_q.pend & ~pend_clr;
        st_d.lost = st_q.lost & ~lost_clr;
        st_d.flag = st_q.flag & ~lost_flag_clr;
        if (frm_valid && best_found) begin
            if (!st_q.pend[best_idx]) begin
                store = 1'b1;
            end else if (!st_q.mb[best_idx].prot) begin
                store     = 1'b1;
                mark_lost = 1'b1;
            end else if (free_found) begin
                store = 1'b1;
                tgt   = free_idx;
            end else begin
                mark_lost = 1'b1;
            end
        end
        if (mark_lost) begin
            st_d.lost[best_idx] = 1'b1;
            st_d.flag           = 1'b1;
        end
        if (store) begin
            st_d.pend[tgt]       = 1'b1;
            st_d.mb[tgt].idw.ide = frm_ide;
            st_d.mb[tgt].idw.id  = fid;
            st_d.mb[tgt].rtr     = frm_rtr;
            st_d.mb[tgt].dlc     = frm_dlc;
            st_d.mb[tgt].data    = frm_data;
        end
        if (cfg_we && (int'(cfg_idx) < NUM_MB)) begin
            st_d.mb[cfg_idx].en   = cfg_en;
            st_d.mb[cfg_idx].rx   = cfg_rx;
            st_d.mb[cfg_idx].prot = cfg_prot;
            st_d.mb[cfg_idx].mask = cfg_mask;
            st_d.mb[cfg_idx].idw  = id_word_t'(cfg_id_word);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_id_word = '0;
        rd_ctrl    = '0;
        rd_data_lo = '0;
        rd_data_hi = '0;
        if (int'(rd_idx) < NUM_MB) begin
            rd_id_word = st_q.mb[rd_idx].idw;
            rd_ctrl    = {st_q.mb[rd_idx].rtr, st_q.mb[rd_idx].dlc};
            rd_data_lo = st_q.mb[rd_idx].data[WORD_W-1:0];
            rd_data_hi = st_q.mb[rd_idx].data[DATA_W-1:WORD_W];
        end
    end

    assign pending   = st_q.pend;
    assign lost      = st_q.lost;
    assign lost_flag = st_q.flag;
endmodule

// File: rtl/rxmb_checker.sv
module rxmb_checker #(
    parameter int NUM_MB = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frm_valid,
    input logic [NUM_MB-1:0] pend_clr,
    input logic [NUM_MB-1:0] pending,
    input logic [NUM_MB-1:0] lost,
    input logic              lost_flag
);
    AST_PEND_RISE_NEEDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        ((pending & ~$past(pending)) != '0) |-> $past(frm_valid)); // R6
    AST_SINGLE_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(pending & ~$past(pending)) <= 1); // R4
    AST_CLEAR_HOLDS_ONLY_ON_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        ((pending & $past(pend_clr) & $past(pending)) != '0) |-> $past(frm_valid)); // R6
    AST_LOST_ONLY_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (lost & ~$past(lost) & ~$past(pending)) == '0); // R7
    AST_LOST_NEEDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        ((lost & ~$past(lost)) != '0) |-> $past(frm_valid)); // R9
    AST_FLAG_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lost_flag) |-> ($past(frm_valid) && ($past(pending) != '0))); // R10
endmodule

bind rxmb_allocator rxmb_checker #(.NUM_MB(NUM_MB)) i_rxmb_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .frm_valid (frm_valid),
    .pend_clr  (pend_clr),
    .pending   (pending),
    .lost      (lost),
    .lost_flag (lost_flag)
);

// File: tb/test_rxmb_allocator.sv
module test_rxmb_allocator;
    localparam int N  = 8;
    localparam int IW = 3;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n;
    logic          cfg_we, cfg_en, cfg_rx, cfg_prot;
    logic [IW-1:0] cfg_idx;
    logic [31:0]   cfg_id_word;
    logic [29:0]   cfg_mask;
    logic          frm_valid, frm_ide, frm_rtr;
    logic [28:0]   frm_id;
    logic [3:0]    frm_dlc;
    logic [63:0]   frm_data;
    logic [N-1:0]  pend_clr, lost_clr;
    logic          lost_flag_clr;
    logic [IW-1:0] rd_idx;
    logic [31:0]   rd_id_word, rd_data_lo, rd_data_hi;
    logic [4:0]    rd_ctrl;
    logic [N-1:0]  pending, lost;
    logic          lost_flag;

    rxmb_allocator #(.NUM_MB(N)) i_rxmb_allocator (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_en(cfg_en), .cfg_rx(cfg_rx),
        .cfg_prot(cfg_prot), .cfg_id_word(cfg_id_word), .cfg_mask(cfg_mask),
        .frm_valid(frm_valid), .frm_ide(frm_ide), .frm_rtr(frm_rtr), .frm_id(frm_id),
        .frm_dlc(frm_dlc), .frm_data(frm_data),
        .pend_clr(pend_clr), .lost_clr(lost_clr), .lost_flag_clr(lost_flag_clr),
        .rd_idx(rd_idx), .rd_id_word(rd_id_word), .rd_ctrl(rd_ctrl),
        .rd_data_lo(rd_data_lo), .rd_data_hi(rd_data_hi),
        .pending(pending), .lost(lost), .lost_flag(lost_flag)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    bit          m_en[N], m_rx[N], m_prot[N];
    logic [31:0] m_idw[N];
    logic [29:0] m_mask[N];
    logic [4:0]  m_ctrl[N];
    logic [63:0] m_data[N];
    logic [N-1:0] m_pend = '0, m_lost = '0;
    logic        m_flag = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [28:0] falign(logic ide, logic [28:0] id);
        return ide ? id : {id[10:0], 18'h0};
    endfunction

    function automatic bit bmatch(int i, logic ide, logic [28:0] id);
        logic [28:0] f, dc, cm;
        bit ideok;
        f     = falign(ide, id);
        dc    = m_idw[i][30] ? m_mask[i][28:0] : 29'h0;
        cm    = ide ? {29{1'b1}} : {11'h7FF, 18'h0};
        ideok = (m_idw[i][31] == ide) || (m_idw[i][30] && m_mask[i][29]);
        return m_en[i] && m_rx[i] && ideok && (((f ^ m_idw[i][28:0]) & ~dc & cm) == 29'h0);
    endfunction

    task automatic step_lfsr();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    endtask

    task automatic cfg(int i, bit en, bit rx, bit prot, logic [31:0] idw, logic [29:0] mask);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = IW'(i); cfg_en = en; cfg_rx = rx; cfg_prot = prot;
        cfg_id_word = idw; cfg_mask = mask;
        m_en[i] = en; m_rx[i] = rx; m_prot[i] = prot; m_idw[i] = idw; m_mask[i] = mask;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic check_mb(int i, string req);
        rd_idx = IW'(i);
        #1;
        chk(req, 64'(rd_id_word), 64'(m_idw[i]));
        chk(req, 64'(rd_ctrl), 64'(m_ctrl[i]));
        chk(req, {rd_data_hi, rd_data_lo}, m_data[i]);
    endtask

    task automatic check_flags(string req);
        chk(req, 64'(pending), 64'(m_pend));
        chk(req, 64'(lost), 64'(m_lost));
        chk(req, 64'(lost_flag), 64'(m_flag));
    endtask

    task automatic frame(string tag, logic ide, logic rtr, logic [28:0] id, logic [3:0] dlc,
                         logic [63:0] data, logic [N-1:0] clr);
        int best, free, tgt;
        string req;
        best = -1; free = -1; tgt = -1;
        for (int i = N - 1; i >= 0; i--) begin
            if (bmatch(i, ide, id)) begin
                if (best < 0) best = i;
                if (free < 0 && !m_pend[i]) free = i;
            end
        end
        if (best < 0) req = "R11";
        else if (!m_pend[best]) begin tgt = best; req = "R4"; end
        else if (!m_prot[best]) begin tgt = best; req = "R7"; m_lost[best] = 1'b1; m_flag = 1'b1; end
        else if (free >= 0) begin tgt = free; req = "R8"; end
        else begin req = "R9"; m_lost[best] = 1'b1; m_flag = 1'b1; end
        m_pend = m_pend & ~clr;
        if (tgt >= 0) begin
            if (clr[tgt]) req = "R6";
            m_pend[tgt] = 1'b1;
            m_idw[tgt]  = {ide, m_idw[tgt][30:29], falign(ide, id)};
            m_ctrl[tgt] = {rtr, dlc};
            m_data[tgt] = data;
        end
        @(negedge clk);
        frm_valid = 1'b1; frm_ide = ide; frm_rtr = rtr; frm_id = id; frm_dlc = dlc;
        frm_data = data; pend_clr = clr;
        @(negedge clk);
        frm_valid = 1'b0; pend_clr = '0;
        check_flags({tag, "/", req});
        if (tgt >= 0) check_mb(tgt, {tag, "/R5"});
        else check_mb((best >= 0) ? best : 0, {tag, "/", req});
    endtask

    task automatic clear(logic [N-1:0] pc, logic [N-1:0] lc, logic fc);
        @(negedge clk);
        pend_clr = pc; lost_clr = lc; lost_flag_clr = fc;
        m_pend = m_pend & ~pc; m_lost = m_lost & ~lc;
        if (fc) m_flag = 1'b0;
        @(negedge clk);
        pend_clr = '0; lost_clr = '0; lost_flag_clr = 1'b0;
        check_flags("R6/R10");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [28:0] fl;
        logic [28:0] fid;
        for (int i = 0; i < N; i++) begin
            m_en[i] = 0; m_rx[i] = 0; m_prot[i] = 0; m_idw[i] = '0; m_mask[i] = '0;
            m_ctrl[i] = '0; m_data[i] = '0;
        end
        rst_n = 1'b0; cfg_we = 0; cfg_idx = '0; cfg_en = 0; cfg_rx = 0; cfg_prot = 0;
        cfg_id_word = '0; cfg_mask = '0; frm_valid = 0; frm_ide = 0; frm_rtr = 0;
        frm_id = '0; frm_dlc = '0; frm_data = '0; pend_clr = '0; lost_clr = '0;
        lost_flag_clr = 0; rd_idx = '0;
        repeat (3) @(negedge clk);
        check_flags("R1");
        rst_n = 1'b1;
        frame("R1", 1'b0, 1'b0, 29'h123, 4'd8, 64'h1111_2222_3333_4444, '0);

        // R2: enabled transmit mailbox and disabled receive mailbox never take frames
        cfg(6, 1, 0, 0, 32'h4000_0000, 30'h3FFF_FFFF);
        cfg(7, 0, 1, 0, 32'h4000_0000, 30'h3FFF_FFFF);
        frame("R2", 1'b1, 1'b0, 29'h0ABC_DEF, 4'd3, 64'h55, '0);
        frame("R2", 1'b0, 1'b1, 29'h7FF, 4'd0, 64'h66, '0);

        // R3: filter sweep on mailbox 0
        for (int k = 0; k < 48; k++) begin
            logic [31:0] idw;
            logic [29:0] msk;
            idw = {k[0], k[1], 1'b0, 29'h0B5A_3C1 ^ {k[5:0], 23'h0} ^ 29'(k * 37)};
            case (k[3:2])
                2'd0: msk = 30'h0;
                2'd1: msk = 30'h0003_FFFF;
                2'd2: msk = 30'h3FFF_FFFF;
                default: msk = 30'h2000_0000;
            endcase
            if (k[4]) msk = msk | 30'h0010_0008;
            cfg(0, 1, 1, 0, idw, msk);
            for (int j = 0; j < 8; j++) begin
                case (j[2:1])
                    2'd0: fl = 29'h0;
                    2'd1: fl = 29'h0010_0000;
                    2'd2: fl = 29'h0000_0008;
                    default: fl = 29'h1000_0000;
                endcase
                fid = idw[28:0] ^ fl;
                frame("R3", j[0], 1'b0, j[0] ? fid : {18'h0, fid[28:18]}, 4'(j), 64'(k * 1000 + j), '0);
                clear('1, '0, 1'b0);
            end
        end
        cfg(0, 0, 1, 0, 32'h0, 30'h0);

        // Directed allocation: mailboxes 0..5 accept all, all protected
        for (int i = 0; i < 6; i++) cfg(i, 1, 1, 1, 32'h4000_0000, 30'h3FFF_FFFF);
        for (int n = 0; n < 7; n++)
            frame("R8", 1'b1, n[0], 29'(n * 29'h111), 4'(n), {32'(n), 32'hCAFE_0000 + 32'(n)}, '0);
        cfg(5, 1, 1, 0, 32'h4000_0000, 30'h3FFF_FFFF);
        frame("R7", 1'b0, 1'b0, 29'h5A5, 4'd8, 64'hDEAD_BEEF_0123_4567, '0);
        frame("R6", 1'b0, 1'b1, 29'h2A, 4'd2, 64'h77, 8'h20);
        clear('0, 8'h20, 1'b0);
        clear('0, '0, 1'b1);
        frame("R10", 1'b1, 1'b0, 29'h1, 4'd1, 64'h88, 8'h01);
        clear('0, '1, 1'b1);
        clear('1, '0, 1'b0);

        // R11: specific filters that a frame misses
        for (int i = 0; i < 6; i++) cfg(i, 1, 1, 0, {1'b0, 2'b00, 11'h155, 18'h0}, 30'h0);
        frame("R11", 1'b0, 1'b0, 29'h2AA, 4'd4, 64'h99, '0);
        frame("R11", 1'b1, 1'b0, {11'h155, 18'h0}, 4'd4, 64'h9A, '0);
        frame("R4", 1'b0, 1'b0, 29'h155, 4'd4, 64'h9B, '0);
        clear('1, '0, 1'b0);

        // Pseudo-random allocation sweep
        for (int i = 0; i < 6; i++) cfg(i, 1, 1, i[0], 32'h4000_0000, 30'h3FFF_FFFF);
        cfg(4, 1, 1, 1, 32'h4000_0000, 30'h3FFB_FFFF);
        for (int it = 0; it < 600; it++) begin
            step_lfsr();
            if (lfsr[3:0] == 4'h0)
                cfg(int'(lfsr[6:4]) % 6, 1, 1, lfsr[7], 32'h4000_0000,
                    (int'(lfsr[6:4]) % 6 == 4) ? 30'h3FFB_FFFF : 30'h3FFF_FFFF);
            if (lfsr[2:0] == 3'h7) clear('0, lfsr[15:8], lfsr[4]);
            frame("sweep", lfsr[8], lfsr[9], {lfsr[12:0], lfsr}, lfsr[12:9],
                  {lfsr, ~lfsr, lfsr ^ 16'h5A5A, 16'(it)},
                  (lfsr[15:13] == 3'h0) ? lfsr[7:0] : 8'h00);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule